// File: doc/BRIEF.md
# Dual-Rate Bus-Matching FIFO Port

This block is the front end that sits on both sides of a FIFO's storage array. On the write side it takes incoming data at one or two transfers per clock and in 10-bit or 20-bit words, and turns them into complete 20-bit storage words. On the read side it does the reverse: it takes 20-bit words from the head of storage and hands them out at one or two transfers per clock, whole or split into 10-bit halves. The storage array, the flags and any clock-domain crossing are outside the block.

Each clock cycle offers two transfer slots per port, one for the rising half and one for the falling half of the clock. An active-low enable, sampled separately for each half, opens the slots. The per-port rate and width settings are captured while master reset is low and then held. A port in double-rate mode may use its falling slot only if its enable was already active for the rising slot of the same cycle. In 10-bit mode the upper half of a storage word always travels first.

Top module: `dr_bm_port`

## Requirements
- R1: The four setting pins (write rate, write width, read rate, read width) are sampled on every clock edge while `mrst_n` is low. Once `mrst_n` is high the captured values are held, and later changes on the pins have no effect.
- R2: A port in double-rate mode (rate pin high) opens both its rising and its falling slot in a cycle where its enable is low for both halves.
- R3: A port in single-rate mode (rate pin low) opens only its rising slot. Its falling-half enable is ignored.
- R4: The falling slot never opens when the enable was high for the rising half, even if the falling-half enable is low. `rd_q_vld[1]` implies `rd_q_vld[0]`.
- R5: In 20-bit write mode, `st_wr_cnt` equals the number of open slots. `st_wr_word0` carries the rising-half data and `st_wr_word1` carries the falling-half data. An unused word output is zero.
- R6: In 10-bit write mode, input data is taken from bits [9:0]. The first 10-bit word of a pair becomes bits [19:10] of the storage word and the second becomes bits [9:0]. A word is committed (`st_wr_cnt`=1, on `st_wr_word0`) only when both halves are present, and never more than one word per cycle.
- R7: In 20-bit read mode, `st_rd_pop` equals the number of open slots. `rd_q_rise` shows `st_head0` and `rd_q_fall` shows `st_head1`.
- R8: In 10-bit read mode, each open slot shows a half-word in bits [9:0], with bits [19:10] zero. The upper half of a head word goes out first and the lower half second. `st_rd_pop` counts one word only when a lower half leaves, and is at most 1 per cycle.
- R9: While `mrst_n` is low no slot opens: `st_wr_cnt`, `st_rd_pop` and `rd_q_vld` are zero. A half-packed write word is discarded by master reset.
- R10: The write and read settings are independent. All sixteen combinations of rate and width work, including all four rate pairings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock |
| mrst_n | input | 1 | Master reset, active low |
| cfg_wr_ddr | input | 1 | Write rate select, 1 = two transfers per clock |
| cfg_wr_narrow | input | 1 | Write width select, 1 = 10-bit |
| cfg_rd_ddr | input | 1 | Read rate select, 1 = two transfers per clock |
| cfg_rd_narrow | input | 1 | Read width select, 1 = 10-bit |
| wr_en_n | input | 1 | Write enable for the rising half, active low |
| wr_en_fall_n | input | 1 | Write enable for the falling half, active low |
| wr_d_rise | input | 20 | Write data for the rising half |
| wr_d_fall | input | 20 | Write data for the falling half |
| st_wr_cnt | output | 2 | Storage words committed this cycle |
| st_wr_word0 | output | 20 | First committed storage word |
| st_wr_word1 | output | 20 | Second committed storage word |
| rd_en_n | input | 1 | Read enable for the rising half, active low |
| rd_en_fall_n | input | 1 | Read enable for the falling half, active low |
| st_head0 | input | 20 | Oldest storage word |
| st_head1 | input | 20 | Next storage word |
| st_rd_pop | output | 2 | Storage words consumed this cycle |
| rd_q_rise | output | 20 | Read data for the rising half |
| rd_q_fall | output | 20 | Read data for the falling half |
| rd_q_vld | output | 2 | Valid bits, [0] rising half and [1] falling half |

## Verification
The assertions assume that both enables stay high while master reset is low. They also assume that storage always holds at least two readable words, because the block has no flags. The stimulus raises all enables before it pulls reset low. It models storage as an endless arithmetic sequence, so both head words are always valid. The setting pins change only after reset is released, and those changes test that they are ignored.

// File: rtl/dr_bm_pkg.sv
package dr_bm_pkg;

    typedef struct packed {
        logic ddr;
        logic narrow;
    } port_cfg_t;

    typedef enum logic {
        PK_EMPTY,
        PK_HALF
    } pk_state_e;

    typedef enum logic {
        UN_UPPER,
        UN_LOWER
    } un_state_e;

endpackage

// File: rtl/dr_cfg_latch.sv
module dr_cfg_latch
    import dr_bm_pkg::*;
(
    input  logic      clk,
    input  logic      mrst_n,
    input  logic      ddr_pin,
    input  logic      narrow_pin,
    output port_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cfg.ddr    <= ddr_pin;
            cfg.narrow <= narrow_pin;
        end
    end
endmodule

// File: rtl/dr_slot_gate.sv
module dr_slot_gate (
    input  logic run,
    input  logic ddr,
    input  logic en_n,
    input  logic en_fall_n,
    output logic slot_r,
    output logic slot_f
);
    always_comb begin
        slot_r = run && !en_n;
        slot_f = slot_r && ddr && !en_fall_n;
    end
endmodule

// File: rtl/dr_wr_packer.sv
module dr_wr_packer
    import dr_bm_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              slot_r,
    input  logic              slot_f,
    input  logic [WORD_W-1:0] d_r,
    input  logic [WORD_W-1:0] d_f,
    output logic [1:0]        cnt,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1
);
    localparam int HALF_W = WORD_W / 2;

    pk_state_e         st, st_nxt;
    logic [HALF_W-1:0] held, held_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= PK_EMPTY;
            held <= '0;
        end else begin
            st   <= st_nxt;
            held <= held_nxt;
        end
    end

    always_comb begin
        st_nxt   = st;
        held_nxt = held;
        if (narrow) begin
            unique case (st)
                PK_EMPTY: begin
                    if (slot_r && !slot_f) begin
                        st_nxt   = PK_HALF;
                        held_nxt = d_r[HALF_W-1:0];
                    end
                end
                PK_HALF: begin
                    if (slot_r && slot_f) begin
                        held_nxt = d_f[HALF_W-1:0];
                    end else if (slot_r) begin
                        st_nxt = PK_EMPTY;
                    end
                end
            endcase
        end
    end

    always_comb begin
        cnt = 2'd0;
        w0  = '0;
        w1  = '0;
        if (!narrow) begin
            cnt = {1'b0, slot_r} + {1'b0, slot_f};
            if (slot_r) w0 = d_r;
            if (slot_f) w1 = d_f;
        end else begin
            unique case (st)
                PK_EMPTY: begin
                    if (slot_r && slot_f) begin
                        cnt = 2'd1;
                        w0  = {d_r[HALF_W-1:0], d_f[HALF_W-1:0]};
                    end
                end
                PK_HALF: begin
                    if (slot_r) begin
                        cnt = 2'd1;
                        w0  = {held, d_r[HALF_W-1:0]};
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dr_rd_unpacker.sv
module dr_rd_unpacker
    import dr_bm_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              slot_r,
    input  logic              slot_f,
    input  logic [WORD_W-1:0] head0,
    input  logic [WORD_W-1:0] head1,
    output logic [1:0]        pop,
    output logic [WORD_W-1:0] q_r,
    output logic [WORD_W-1:0] q_f,
    output logic [1:0]        vld
);
    localparam int HALF_W = WORD_W / 2;

    un_state_e st, st_nxt;

    function automatic logic [WORD_W-1:0] upper_of(input logic [WORD_W-1:0] x);
        return {{HALF_W{1'b0}}, x[WORD_W-1:HALF_W]};
    endfunction

    function automatic logic [WORD_W-1:0] lower_of(input logic [WORD_W-1:0] x);
        return {{HALF_W{1'b0}}, x[HALF_W-1:0]};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= UN_UPPER;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (narrow && slot_r && !slot_f) begin
            unique case (st)
                UN_UPPER: st_nxt = UN_LOWER;
                UN_LOWER: st_nxt = UN_UPPER;
            endcase
        end
    end

    always_comb begin
        pop = 2'd0;
        q_r = '0;
        q_f = '0;
        vld = {slot_f, slot_r};
        if (!narrow) begin
            pop = {1'b0, slot_r} + {1'b0, slot_f};
            if (slot_r) q_r = head0;
            if (slot_f) q_f = head1;
        end else begin
            unique case (st)
                UN_UPPER: begin
                    if (slot_r) q_r = upper_of(head0);
                    if (slot_f) begin
                        q_f = lower_of(head0);
                        pop = 2'd1;
                    end
                end
                UN_LOWER: begin
                    if (slot_r) begin
                        q_r = lower_of(head0);
                        pop = 2'd1;
                    end
                    if (slot_f) q_f = upper_of(head1);
                end
            endcase
        end
    end
endmodule

// File: rtl/dr_bm_port.sv
module dr_bm_port
    import dr_bm_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              cfg_wr_ddr,
    input  logic              cfg_wr_narrow,
    input  logic              cfg_rd_ddr,
    input  logic              cfg_rd_narrow,
    input  logic              wr_en_n,
    input  logic              wr_en_fall_n,
    input  logic [WORD_W-1:0] wr_d_rise,
    input  logic [WORD_W-1:0] wr_d_fall,
    output logic [1:0]        st_wr_cnt,
    output logic [WORD_W-1:0] st_wr_word0,
    output logic [WORD_W-1:0] st_wr_word1,
    input  logic              rd_en_n,
    input  logic              rd_en_fall_n,
    input  logic [WORD_W-1:0] st_head0,
    input  logic [WORD_W-1:0] st_head1,
    output logic [1:0]        st_rd_pop,
    output logic [WORD_W-1:0] rd_q_rise,
    output logic [WORD_W-1:0] rd_q_fall,
    output logic [1:0]        rd_q_vld
);
    port_cfg_t wr_cfg, rd_cfg;
    logic      wr_ddr_q, wr_narrow_q, rd_ddr_q, rd_narrow_q;
    logic      wr_slot_r, wr_slot_f, rd_slot_r, rd_slot_f;

    dr_cfg_latch u_wr_cfg (
        .clk(wr_clk), .mrst_n(mrst_n),
        .ddr_pin(cfg_wr_ddr), .narrow_pin(cfg_wr_narrow), .cfg(wr_cfg)
    );

    dr_cfg_latch u_rd_cfg (
        .clk(rd_clk), .mrst_n(mrst_n),
        .ddr_pin(cfg_rd_ddr), .narrow_pin(cfg_rd_narrow), .cfg(rd_cfg)
    );

    assign wr_ddr_q    = wr_cfg.ddr;
    assign wr_narrow_q = wr_cfg.narrow;
    assign rd_ddr_q    = rd_cfg.ddr;
    assign rd_narrow_q = rd_cfg.narrow;

    dr_slot_gate u_wr_gate (
        .run(mrst_n), .ddr(wr_ddr_q), .en_n(wr_en_n), .en_fall_n(wr_en_fall_n),
        .slot_r(wr_slot_r), .slot_f(wr_slot_f)
    );

    dr_slot_gate u_rd_gate (
        .run(mrst_n), .ddr(rd_ddr_q), .en_n(rd_en_n), .en_fall_n(rd_en_fall_n),
        .slot_r(rd_slot_r), .slot_f(rd_slot_f)
    );

    dr_wr_packer #(.WORD_W(WORD_W)) u_pack (
        .clk(wr_clk), .rst_n(mrst_n), .narrow(wr_narrow_q),
        .slot_r(wr_slot_r), .slot_f(wr_slot_f),
        .d_r(wr_d_rise), .d_f(wr_d_fall),
        .cnt(st_wr_cnt), .w0(st_wr_word0), .w1(st_wr_word1)
    );

    dr_rd_unpacker #(.WORD_W(WORD_W)) u_unpack (
        .clk(rd_clk), .rst_n(mrst_n), .narrow(rd_narrow_q),
        .slot_r(rd_slot_r), .slot_f(rd_slot_f),
        .head0(st_head0), .head1(st_head1),
        .pop(st_rd_pop), .q_r(rd_q_rise), .q_f(rd_q_fall), .vld(rd_q_vld)
    );
endmodule

// File: rtl/dr_bm_port_chk.sv
module dr_bm_port_chk #(
    parameter int WORD_W = 20
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst_n,
    input logic              wr_ddr_q,
    input logic              wr_narrow_q,
    input logic              rd_ddr_q,
    input logic              rd_narrow_q,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic [1:0]        st_wr_cnt,
    input logic [1:0]        st_rd_pop,
    input logic [WORD_W-1:0] rd_q_rise,
    input logic [WORD_W-1:0] rd_q_fall,
    input logic [1:0]        rd_q_vld
);
    localparam int HALF_W = WORD_W / 2;

    AST_WR_CFG_HELD: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(wr_ddr_q) && $stable(wr_narrow_q)); // R1
    AST_RD_CFG_HELD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(rd_ddr_q) && $stable(rd_narrow_q)); // R1
    AST_WR_SDR_ONE: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !wr_ddr_q |-> st_wr_cnt <= 2'd1); // R3
    AST_RD_SDR_ONE: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        !rd_ddr_q |-> !rd_q_vld[1]); // R3
    AST_WR_IDLE_NO_COMMIT: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        wr_en_n |-> st_wr_cnt == 2'd0); // R4
    AST_RD_FALL_NEEDS_RISE: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        rd_q_vld[1] |-> rd_q_vld[0] && !rd_en_n); // R4
    AST_NARROW_WR_ONE: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        wr_narrow_q |-> st_wr_cnt <= 2'd1); // R6
    AST_NARROW_RD_POP: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        rd_narrow_q |-> st_rd_pop <= 2'd1); // R8
    AST_NARROW_RD_UPPER_ZERO: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        rd_narrow_q |-> rd_q_rise[WORD_W-1:HALF_W] == '0 && rd_q_fall[WORD_W-1:HALF_W] == '0); // R8

    always @(posedge wr_clk) begin
        if (!mrst_n) begin
            AST_RST_ENABLES_HIGH: assert (wr_en_n && rd_en_n); // R9
            AST_RST_QUIET: assert (st_wr_cnt == 2'd0 && st_rd_pop == 2'd0 && rd_q_vld == 2'd0); // R9
        end
    end
endmodule

bind dr_bm_port dr_bm_port_chk u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n),
    .wr_ddr_q(wr_ddr_q), .wr_narrow_q(wr_narrow_q),
    .rd_ddr_q(rd_ddr_q), .rd_narrow_q(rd_narrow_q),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .st_wr_cnt(st_wr_cnt), .st_rd_pop(st_rd_pop),
    .rd_q_rise(rd_q_rise), .rd_q_fall(rd_q_fall), .rd_q_vld(rd_q_vld)
);

// File: tb/sim_dr_bm_port.sv
module sim_dr_bm_port;
    logic        clk = 1'b0;
    logic        mrst_n;
    logic        p_wddr, p_wnar, p_rddr, p_rnar;
    logic        wr_en_n, wr_en_fall_n, rd_en_n, rd_en_fall_n;
    logic [19:0] wr_d_rise, wr_d_fall, st_head0, st_head1;
    logic [1:0]  st_wr_cnt, st_rd_pop, rd_q_vld;
    logic [19:0] st_wr_word0, st_wr_word1, rd_q_rise, rd_q_fall;

    int checks = 0;
    int failures = 0;
    int dn = 0;
    int hp = 0;
    logic m_wddr, m_wnar, m_rddr, m_rnar;
    logic m_half, m_lower;
    logic [9:0] m_held;

    always #5 clk = ~clk;

    dr_bm_port u0 (
        .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n),
        .cfg_wr_ddr(p_wddr), .cfg_wr_narrow(p_wnar),
        .cfg_rd_ddr(p_rddr), .cfg_rd_narrow(p_rnar),
        .wr_en_n(wr_en_n), .wr_en_fall_n(wr_en_fall_n),
        .wr_d_rise(wr_d_rise), .wr_d_fall(wr_d_fall),
        .st_wr_cnt(st_wr_cnt), .st_wr_word0(st_wr_word0), .st_wr_word1(st_wr_word1),
        .rd_en_n(rd_en_n), .rd_en_fall_n(rd_en_fall_n),
        .st_head0(st_head0), .st_head1(st_head1),
        .st_rd_pop(st_rd_pop), .rd_q_rise(rd_q_rise), .rd_q_fall(rd_q_fall),
        .rd_q_vld(rd_q_vld)
    );

    function automatic logic [19:0] wval(input int n);
        return 20'(n * 7919 + 11);
    endfunction

    function automatic logic [19:0] hval(input int n);
        return 20'(n * 321 + 4099);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] cfg);
        @(negedge clk);
        wr_en_n = 1'b1; wr_en_fall_n = 1'b1; rd_en_n = 1'b1; rd_en_fall_n = 1'b1;
        mrst_n = 1'b0;
        {p_wddr, p_wnar, p_rddr, p_rnar} = cfg;
        repeat (3) @(negedge clk);
        #2;
        check(st_wr_cnt == 0 && st_rd_pop == 0 && rd_q_vld == 0, "R9", "quiet in reset",
              {st_wr_cnt, st_rd_pop, rd_q_vld}, 64'd0);
        @(negedge clk);
        mrst_n = 1'b1;
        {p_wddr, p_wnar, p_rddr, p_rnar} = ~cfg; // R1: pins change after capture
        {m_wddr, m_wnar, m_rddr, m_rnar} = cfg;
        m_half = 1'b0; m_lower = 1'b0; m_held = '0; hp = 0;
    endtask

    task automatic step(input logic we, input logic wef, input logic re, input logic ref_n);
        logic wr, wf, rr, rf, n_half, n_lower;
        logic [9:0] n_held;
        logic [1:0] ec, ep, ev;
        logic [19:0] e0, e1, eqr, eqf, h0, h1;
        string wreq, rreq;
        @(negedge clk);
        wr_en_n = we; wr_en_fall_n = wef; rd_en_n = re; rd_en_fall_n = ref_n;
        wr_d_rise = wval(dn); wr_d_fall = wval(dn + 1); dn += 2;
        h0 = hval(hp); h1 = hval(hp + 1);
        st_head0 = h0; st_head1 = h1;
        #2;
        wr = !we; wf = wr && m_wddr && !wef;
        rr = !re; rf = rr && m_rddr && !ref_n;
        n_half = m_half; n_held = m_held; n_lower = m_lower;
        ec = 0; e0 = 0; e1 = 0;
        if (!m_wnar) begin
            wreq = "R5";
            ec = 2'(wr) + 2'(wf);
            if (wr) e0 = wr_d_rise;
            if (wf) e1 = wr_d_fall;
        end else begin
            wreq = "R6";
            if (wr && wf) begin
                ec = 1;
                e0 = m_half ? {m_held, wr_d_rise[9:0]} : {wr_d_rise[9:0], wr_d_fall[9:0]};
                if (m_half) n_held = wr_d_fall[9:0];
            end else if (wr) begin
                if (m_half) begin ec = 1; e0 = {m_held, wr_d_rise[9:0]}; n_half = 0; end
                else begin n_half = 1; n_held = wr_d_rise[9:0]; end
            end
        end
        ep = 0; eqr = 0; eqf = 0; ev = {rf, rr};
        if (!m_rnar) begin
            rreq = "R7";
            ep = 2'(rr) + 2'(rf);
            if (rr) eqr = h0;
            if (rf) eqf = h1;
        end else begin
            rreq = "R8";
            if (rr && rf) begin
                ep = 1;
                eqr = m_lower ? {10'd0, h0[9:0]} : {10'd0, h0[19:10]};
                eqf = m_lower ? {10'd0, h1[19:10]} : {10'd0, h0[9:0]};
            end else if (rr) begin
                eqr = m_lower ? {10'd0, h0[9:0]} : {10'd0, h0[19:10]};
                ep = m_lower ? 2'd1 : 2'd0;
                n_lower = !m_lower;
            end
        end
        // R2 R3 R4 R10: slot counts above follow rate and enables per port
        check(st_wr_cnt == ec && st_wr_word0 == e0 && st_wr_word1 == e1, wreq, "write side",
              {st_wr_cnt, st_wr_word0, st_wr_word1}, {ec, e0, e1});
        check(st_rd_pop == ep && rd_q_rise == eqr && rd_q_fall == eqf && rd_q_vld == ev,
              rreq, "read side", {st_rd_pop, rd_q_vld, rd_q_rise, rd_q_fall},
              {ep, ev, eqr, eqf});
        @(posedge clk);
        m_half = n_half; m_held = n_held; m_lower = n_lower; hp += int'(ep);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mrst_n = 1'b0;
        wr_en_n = 1'b1; wr_en_fall_n = 1'b1; rd_en_n = 1'b1; rd_en_fall_n = 1'b1;
        {p_wddr, p_wnar, p_rddr, p_rnar} = 4'b0;
        wr_d_rise = '0; wr_d_fall = '0; st_head0 = '0; st_head1 = '0;
        // R10: every combination of write and read settings
        for (int c = 0; c < 16; c++) begin
            do_reset(4'(c));
            for (int i = 0; i < 32; i++) begin
                int pw, pr;
                pw = i % 4;
                pr = (i * 3 + 1) % 4;
                step(pw[1], pw[0], pr[1], pr[0]);
            end
        end
        // R9: a half-packed word is dropped by master reset
        do_reset(4'b0100);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        do_reset(4'b0100);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        // R4: enable only for the falling half gives nothing on either port
        do_reset(4'b1010);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check(1'b1, "R4", "fall-only enable", 64'd0, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule